// File: doc/BRIEF.md
# Clock Crosspoint with Glitch-Free Post Dividers

This block steers four source clocks to three clock outputs. The sources are a reference clock and three synthesized clocks. Any source can feed any output, and each output can take the inverted phase of its source. When one source drives several outputs, inverting the phase on one of them keeps their edges from landing together. Each output then passes through its own seven-bit post divider. For outputs A and B, a frequency-select level picks one of two divide values. Output C has a single divide value.

The block runs on a fast system clock and oversamples the source clocks. Each divider counts source half-periods. A divide value N therefore gives N half-periods high and N half-periods low. The duty cycle is 50% for odd and for even N. Every output period starts on a rising edge of the chosen source phase. A new divide value, including one brought in by the frequency select, loads only at that period boundary. As a result, the output never shows a runt pulse.

A divide value of zero, or a deasserted enable, parks the output low at the next period boundary. A separate tristate request from outside removes the output drive.

Top module: `clk_xpoint`

## Requirements
- R1: Output k is driven from the source whose index is held in bits [2k+1:2k] of `src_sel`. Any of the four sources can reach any of the three outputs.
- R2: For a steady divide value N ≥ 1, every high time and every low time of the output lasts exactly N half-periods of the selected source. The output changes only after a change on the selected source phase.
- R3: With N = 1, the output follows the selected source phase, toggling once for each source edge.
- R4: Output A uses `div_a0` while `fs` is 0 and `div_a1` while `fs` is 1. Output B uses `div_b0` or `div_b1` under the same rule. Output C always uses `div_c` and does not react to `fs`.
- R5: A change of divide value takes effect only at the next period boundary. Across a change from N1 to N2, no high or low time is shorter than min(N1, N2) source half-periods.
- R6: When bit k of `phase_inv` is 1, output k is built from the inverted source. With N = 1, an inverted and a non-inverted output on the same source are always complementary.
- R7: When the active divide value is 0, or bit k of `out_en` is 0, output k stops at its next period boundary and then stays low. A low output stays low for as long as that condition holds.
- R8: `clk_oe[k]` is 0 while `tri_req[k]` is 1. It is also 0 while `out_en[k]` is 0 and the active divide value of that output is 0. Otherwise it is 1.
- R9: While `rst_n` is low, all clock outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the sources |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_clk | input | NSRC | Source clocks; index 0 is the reference |
| src_sel | input | 3*clog2(NSRC) | Source index per output, output A in the low field |
| phase_inv | input | 3 | Per-output source phase inversion |
| fs | input | 1 | Frequency select for outputs A and B |
| div_a0 | input | DW | Output A divide value while fs = 0 |
| div_a1 | input | DW | Output A divide value while fs = 1 |
| div_b0 | input | DW | Output B divide value while fs = 0 |
| div_b1 | input | DW | Output B divide value while fs = 1 |
| div_c | input | DW | Output C divide value |
| out_en | input | 3 | Per-output enable |
| tri_req | input | 3 | Per-output tristate request |
| clk_out | output | 3 | Divided clock outputs A, B, C |
| clk_oe | output | 3 | Output drive enable for each clock |

## Verification
The checker assumes three things about the inputs:
- The source clocks, `src_sel` and `phase_inv` change only between system clock edges.
- Each source stays at a level for at least two system clock cycles, so that every source edge is seen as a separate event.
- The output is allowed to move only in the cycle after one of these inputs changes.

The bench meets these assumptions. It toggles each source from a counter on the falling system edge, with half-periods of two to five cycles. It changes configuration only on falling edges. It measures pulse widths only after discarding the runs that straddle a reconfiguration.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
   localparam int XPT_NOUT = 3;
   localparam int XPT_NDUAL = 2;   // outputs A and B carry two divide values

   typedef enum int {
      XPT_A = 0,
      XPT_B = 1,
      XPT_C = 2
   } xpt_out_e;
endpackage

// File: rtl/xpt_src_tap.sv
// Selects one oversampled source, applies optional inversion and reports
// any edge and rising edges of the resulting phase.
module xpt_src_tap #(
   parameter int NSRC = 4,
   parameter int SW   = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] src_s,
   input  logic [SW-1:0]   sel,
   input  logic            inv,
   output logic            edge_any,
   output logic            edge_rise
);
   logic ph;
   logic ph_q;

   always_comb begin
      if (32'(sel) < NSRC) ph = src_s[sel] ^ inv;
      else                 ph = inv;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph_q <= 1'b0;
      else        ph_q <= ph;
   end

   assign edge_any  = ph ^ ph_q;
   assign edge_rise = ph & ~ph_q;
endmodule

// File: rtl/xpt_half_div.sv
// Half-period divider: N half-periods high, N low. The divide value is
// reloaded only at a period boundary, which falls on a rising phase edge.
module xpt_half_div #(
   parameter int DW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          edge_any,
   input  logic          edge_rise,
   input  logic [DW-1:0] nxt_div,
   output logic          div_out
);
   logic [DW-1:0] act_q;
   logic [DW-1:0] cnt_q;
   logic          out_q;
   logic          idle;
   logic          last;

   assign idle = (act_q == '0);
   assign last = (cnt_q == act_q - DW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= '0;
         cnt_q <= '0;
         out_q <= 1'b0;
      end else if (edge_any) begin
         if (idle) begin
            if (edge_rise) begin
               act_q <= nxt_div;
               cnt_q <= '0;
               out_q <= (nxt_div != '0);
            end
         end else if (last) begin
            cnt_q <= '0;
            if (out_q) begin
               out_q <= 1'b0;
            end else begin
               act_q <= nxt_div;
               out_q <= (nxt_div != '0);
            end
         end else begin
            cnt_q <= cnt_q + DW'(1);
         end
      end
   end

   assign div_out = out_q;
endmodule

// File: rtl/clk_xpoint.sv
module clk_xpoint
   import xpt_pkg::*;
#(
   parameter int NSRC = 4,
   parameter int DW   = 7
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [NSRC-1:0]                 src_clk,
   input  logic [3*$clog2(NSRC)-1:0]       src_sel,
   input  logic [2:0]                      phase_inv,
   input  logic                            fs,
   input  logic [DW-1:0]                   div_a0,
   input  logic [DW-1:0]                   div_a1,
   input  logic [DW-1:0]                   div_b0,
   input  logic [DW-1:0]                   div_b1,
   input  logic [DW-1:0]                   div_c,
   input  logic [2:0]                      out_en,
   input  logic [2:0]                      tri_req,
   output logic [2:0]                      clk_out,
   output logic [2:0]                      clk_oe
);
   localparam int SW = $clog2(NSRC);

   if (NSRC < 2) begin : g_bad_nsrc
      $error("clk_xpoint: NSRC must be at least 2");
   end
   if (DW < 2) begin : g_bad_dw
      $error("clk_xpoint: DW must be at least 2");
   end

   logic [NSRC-1:0]          src_s;
   logic [XPT_NOUT-1:0][DW-1:0] cfg_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) src_s <= '0;
      else        src_s <= src_clk;
   end

   assign cfg_sel[XPT_A] = fs ? div_a1 : div_a0;
   assign cfg_sel[XPT_B] = fs ? div_b1 : div_b0;
   assign cfg_sel[XPT_C] = div_c;

   for (genvar g = 0; g < XPT_NOUT; g++) begin : g_out
      logic          e_any;
      logic          e_rise;
      logic [DW-1:0] nxt;

      assign nxt = out_en[g] ? cfg_sel[g] : '0;

      xpt_src_tap #(.NSRC(NSRC), .SW(SW)) u_tap (
         .clk       (clk),
         .rst_n     (rst_n),
         .src_s     (src_s),
         .sel       (src_sel[g*SW +: SW]),
         .inv       (phase_inv[g]),
         .edge_any  (e_any),
         .edge_rise (e_rise)
      );

      xpt_half_div #(.DW(DW)) u_div (
         .clk       (clk),
         .rst_n     (rst_n),
         .edge_any  (e_any),
         .edge_rise (e_rise),
         .nxt_div   (nxt),
         .div_out   (clk_out[g])
      );

      assign clk_oe[g] = ~tri_req[g] & (out_en[g] | (cfg_sel[g] != '0));
   end
endmodule

// File: rtl/clk_xpoint_chk.sv
module clk_xpoint_chk #(
   parameter int NSRC = 4,
   parameter int DW   = 7
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [NSRC-1:0]           src_clk,
   input logic [3*$clog2(NSRC)-1:0] src_sel,
   input logic [2:0]                phase_inv,
   input logic                      fs,
   input logic [DW-1:0]             div_a0,
   input logic [DW-1:0]             div_a1,
   input logic [DW-1:0]             div_b0,
   input logic [DW-1:0]             div_b1,
   input logic [DW-1:0]             div_c,
   input logic [2:0]                out_en,
   input logic [2:0]                tri_req,
   input logic [2:0]                clk_out,
   input logic [2:0]                clk_oe
);
   logic [NSRC-1:0] s1;
   logic            ready;
   logic [2:0]      live;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1    <= '0;
         ready <= 1'b0;
      end else begin
         s1    <= src_clk;
         ready <= 1'b1;
      end
   end

   assign live[0] = out_en[0] && ((fs ? div_a1 : div_a0) != '0);
   assign live[1] = out_en[1] && ((fs ? div_b1 : div_b0) != '0);
   assign live[2] = out_en[2] && (div_c != '0);

   for (genvar g = 0; g < 3; g++) begin : g_chk
      // R2: without a source, select or phase change, the output holds
      assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (ready && $stable(s1) && $stable(src_sel) && $stable(phase_inv))
            |=> $stable(clk_out[g]));

      // R7: a parked output never leaves low
      assert_hold_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (!live[g] && !clk_out[g]) |=> !clk_out[g]);

      // R8: a tristate request always removes drive
      assert_tristate_R8: assert property (@(posedge clk) disable iff (!rst_n)
         tri_req[g] |-> !clk_oe[g]);
   end

   // R9: outputs low during reset
   assert_reset_low_R9: assert property (@(posedge clk)
      !rst_n |=> (clk_out == 3'b000));
endmodule

bind clk_xpoint clk_xpoint_chk #(.NSRC(NSRC), .DW(DW)) u_chk (.*);

// File: tb/clk_xpoint_tb_top.sv
module clk_xpoint_tb_top;
   localparam int NSRC = 4;
   localparam int DW   = 7;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NSRC-1:0] src_clk = '0;
   logic [5:0]      src_sel = '0;
   logic [2:0]      phase_inv = '0;
   logic            fs = 1'b0;
   logic [DW-1:0]   div_a0 = 7'd1, div_a1 = 7'd1, div_b0 = 7'd1, div_b1 = 7'd1, div_c = 7'd1;
   logic [2:0]      out_en = 3'b111;
   logic [2:0]      tri_req = 3'b000;
   logic [2:0]      clk_out;
   logic [2:0]      clk_oe;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   // source half-periods in system cycles
   int half [NSRC] = '{3, 4, 5, 2};
   int scnt [NSRC] = '{0, 0, 0, 0};

   always #4 clk = ~clk;   // 125 MHz

   always @(negedge clk) begin
      for (int s = 0; s < NSRC; s++) begin
         if (scnt[s] == half[s] - 1) begin
            scnt[s] = 0;
            src_clk[s] <= ~src_clk[s];
         end else begin
            scnt[s] = scnt[s] + 1;
         end
      end
   end

   clk_xpoint #(.NSRC(NSRC), .DW(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .src_clk(src_clk), .src_sel(src_sel),
      .phase_inv(phase_inv), .fs(fs), .div_a0(div_a0), .div_a1(div_a1),
      .div_b0(div_b0), .div_b1(div_b1), .div_c(div_c), .out_en(out_en),
      .tri_req(tri_req), .clk_out(clk_out), .clk_oe(clk_oe)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic run_len(input int o, output int len);
      logic lv;
      int c = 0;
      lv = clk_out[o];
      do begin
         @(negedge clk);
         c++;
      end while (clk_out[o] == lv && c < 4000);
      len = c;
   endtask

   // discard settling runs, then gather min and max of n runs
   task automatic measure(input int o, input int n, output int mn, output int mx);
      int l;
      for (int k = 0; k < 4; k++) run_len(o, l);
      mn = 1 << 30;
      mx = 0;
      for (int k = 0; k < n; k++) begin
         run_len(o, l);
         if (l < mn) mn = l;
         if (l > mx) mx = l;
      end
   endtask

   task automatic watch_min(input int o, input int cycles, output int mn);
      logic lv;
      int c = 0;
      int t = 0;
      bit started = 0;
      mn = 1 << 30;
      lv = clk_out[o];
      for (int k = 0; k < cycles; k++) begin
         @(negedge clk);
         c++;
         if (clk_out[o] != lv) begin
            if (started && c < mn) mn = c;
            started = 1;
            c = 0;
            lv = clk_out[o];
            t++;
         end
      end
   endtask

   task automatic count_high(input int o, input int cycles, output int ones);
      ones = 0;
      for (int k = 0; k < cycles; k++) begin
         @(negedge clk);
         if (clk_out[o]) ones++;
      end
   endtask

   task automatic t_reset;
      repeat (5) @(negedge clk);
      check(clk_out == 3'b000, "R9 outputs low in reset", int'(clk_out), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(clk_out == 3'b000, "R9 outputs low after reset", int'(clk_out), 0);
      check(clk_oe == 3'b111, "R8 drive on by default", int'(clk_oe), 7);
   endtask

   task automatic t_route;
      int mn, mx;
      // A<-src0 div3, B<-src1 div2, C<-src2 div5
      src_sel = {2'd2, 2'd1, 2'd0};
      div_a0 = 7'd3; div_b0 = 7'd2; div_c = 7'd5;
      measure(0, 6, mn, mx);
      check(mn == 9 && mx == 9, "R2 odd divide on A", mn, 9);
      measure(1, 6, mn, mx);
      check(mn == 8 && mx == 8, "R1 B from src1", mn, 8);
      measure(2, 4, mn, mx);
      check(mn == 25 && mx == 25, "R2 C from src2", mx, 25);
      // A<-src3 div4, B<-src2 div1, C<-src0 div7
      src_sel = {2'd0, 2'd2, 2'd3};
      div_a0 = 7'd4; div_b0 = 7'd1; div_c = 7'd7;
      measure(0, 6, mn, mx);
      check(mn == 8 && mx == 8, "R1 A from src3", mn, 8);
      measure(1, 8, mn, mx);
      check(mn == 5 && mx == 5, "R3 divide by one follows source", mn, 5);
      measure(2, 4, mn, mx);
      check(mn == 21 && mx == 21, "R1 C from src0", mx, 21);
   endtask

   task automatic t_phase;
      int same = 0;
      int mn, mx;
      src_sel = {2'd1, 2'd2, 2'd1};
      div_a0 = 7'd1; div_c = 7'd1;
      phase_inv = 3'b100;
      measure(0, 4, mn, mx);
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         if (clk_out[0] == clk_out[2]) same++;
      end
      check(same == 0, "R6 inverted phase complementary", same, 0);
      phase_inv = 3'b000;
   endtask

   task automatic t_fs;
      int mn, mx, ma, mb, mc;
      src_sel = {2'd2, 2'd3, 2'd0};
      div_a0 = 7'd2; div_a1 = 7'd5;
      div_b0 = 7'd3; div_b1 = 7'd1;
      div_c = 7'd4;
      fs = 1'b0;
      measure(0, 6, mn, mx);
      check(mn == 6 && mx == 6, "R4 A uses first value at fs 0", mn, 6);
      measure(1, 6, mn, mx);
      check(mn == 6 && mx == 6, "R4 B uses first value at fs 0", mn, 6);
      fork
         watch_min(0, 300, ma);
         watch_min(1, 300, mb);
         watch_min(2, 300, mc);
         begin
            repeat (37) @(negedge clk);
            fs = 1'b1;
         end
      join
      check(ma >= 6, "R5 no runt on A across fs", ma, 6);
      check(mb >= 2, "R5 no runt on B across fs", mb, 2);
      check(mc == 20, "R4 C unaffected by fs", mc, 20);
      measure(0, 6, mn, mx);
      check(mn == 15 && mx == 15, "R4 A uses second value at fs 1", mn, 15);
      measure(1, 6, mn, mx);
      check(mn == 2 && mx == 2, "R4 B uses second value at fs 1", mn, 2);
   endtask

   task automatic t_park;
      int ones, mn, mx;
      out_en[1] = 1'b0;
      repeat (100) @(negedge clk);
      count_high(1, 60, ones);
      check(ones == 0, "R7 disabled output held low", ones, 0);
      check(clk_oe[1] == 1'b1, "R8 drive kept with nonzero divide", int'(clk_oe[1]), 1);
      div_c = 7'd0;
      repeat (100) @(negedge clk);
      count_high(2, 60, ones);
      check(ones == 0, "R7 divide zero held low", ones, 0);
      check(clk_oe[2] == 1'b1, "R8 drive kept while enabled", int'(clk_oe[2]), 1);
      out_en[2] = 1'b0;
      @(negedge clk);
      check(clk_oe[2] == 1'b0, "R8 tristate on zero divide and disable", int'(clk_oe[2]), 0);
      tri_req[0] = 1'b1;
      @(negedge clk);
      check(clk_oe[0] == 1'b0, "R8 tristate request", int'(clk_oe[0]), 0);
      tri_req[0] = 1'b0;
      @(negedge clk);
      check(clk_oe[0] == 1'b1, "R8 tristate request released", int'(clk_oe[0]), 1);
      out_en[1] = 1'b1;
      measure(1, 6, mn, mx);
      check(mn == 2 && mx == 2, "R7 output resumes after enable", mn, 2);
   endtask

   initial begin
      t_reset();
      t_route();
      t_phase();
      t_fs();
      t_park();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule